// File: doc/BRIEF.md
# Command-Buffered SPI Master Engine

This block is an SPI master that runs one self-described transaction out of a shared byte buffer. The host fills the buffer while the engine is idle. Bytes 0 and 1 hold a 16-bit command word that carries an operation code and a byte count. The bytes to send follow from offset 2. The host then writes a start word that picks one of the chip selects and one of the timing profiles. The engine reads the command word and drives the selected chip select low. It shifts the bytes MSB first, writes any received bytes back into the buffer from offset 0, releases the chip select and raises a completion flag.

A read can be preceded by a short write phase of up to 15 bytes, taken from the profile, without releasing the chip select in between. This serves the usual send-an-opcode-then-read pattern of serial memories. The serial clock advances one half period for each cycle in which the `tick` input is high, so the bit rate is set outside the block.

Control goes through a small write-only register port, selected by `reg_sel`:
- 0 is start.
- 1 is the global clock idle level.
- 2 is the interrupt mask.
- 3 is the status clear.
- 4 is a profile entry.

Top module: `spi_cmd_engine`

## Requirements
- R1: The command word is big-endian: buffer byte 0 is bits 15:8 and byte 1 is bits 7:0. Bits 15:13 are the operation code (1 = full duplex, 2 = write only, 3 = read only) and bits 12:0 are the byte count. Exactly that many bytes, plus any prepend bytes, cross the wire.
- R2: Write only sends the count bytes from buffer offset 2 upward, MSB first. It leaves the buffer unchanged and ignores the profile's prepend count.
- R3: Full duplex sends the count bytes from offset 2 upward. It stores received byte k at offset k.
- R4: Read only first sends the profile's prepend count P (0 to 15) of bytes from offset 2. It then clocks the count bytes with MOSI held low and stores received byte j of that phase at offset j. All of this happens under one chip-select assertion.
- R5: Operation codes 0 and 4 to 7, a count of 0 and a count above the buffer size complete without asserting any chip select and without any serial clock edge. They still set the completion status.
- R6: Start word (sel 0): bit 15 = go, bits 2:0 = chip-select index, bits 10:8 = profile index. Only the indexed active-low `cs_n` bit is driven low during the transfer, and all are high again when `busy` falls.
- R7: Global sel 1 bit 0 sets the clock idle level. A profile (sel 4: bits 10:8 index, bit 4 phase, bits 3:0 prepend count) with phase 0 samples on the edge leaving the idle level and changes MOSI on the edge returning to it. Phase 1 does the reverse. Each byte takes 16 clock edges, and the clock moves only on `tick`.
- R8: `busy` is high from the start write until completion. Start words and host buffer writes arriving while busy are ignored and are not queued.
- R9: Completion sets `int_status`, and `irq` is `int_status` gated by mask bit 0 (sel 2). Writing 0xFFFF to sel 3 clears the status. Any other value leaves it set.
- R10: After reset, `busy` and `int_status` are 0, `irq` is 0, all `cs_n` bits are 1 and `sclk` idles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-bit-period enable for the serial clock |
| buf_we | input | 1 | Host buffer write strobe (ignored while busy) |
| buf_addr | input | 9 | Host buffer byte address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Buffer byte at `buf_addr` (combinational) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 start, 1 idle level, 2 mask, 3 clear, 4 profile) |
| reg_wdata | input | 16 | Register write data |
| busy | output | 1 | Transaction in progress |
| int_status | output | 1 | Completion status |
| irq | output | 1 | Masked completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
A wrong byte index or a wrong phase test shows up quickly. It gives either a misplaced byte in the buffer read back right after `busy` falls, or a wrong bit captured by the slave model at the first sampling edge of the affected byte. A wrong transfer total shows up as a wrong number of serial clock edges or captured bits at the end of the command, a few hundred cycles later at most. A bad command-word decode shows up as a chip select that is asserted when it should not be, or the reverse. Control-path faults in busy gating or status handling show at the ports within one or two cycles of the offending write.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int BUF_BYTES = 512,
  parameter int NUM_CS    = 8,
  parameter int NUM_PROF  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_BYTES)-1:0] buf_addr,
  input  logic [7:0]                   buf_wdata,
  output logic [7:0]                   buf_rdata,
  input  logic                         reg_we,
  input  logic [2:0]                   reg_sel,
  input  logic [15:0]                  reg_wdata,
  output logic                         busy,
  output logic                         int_status,
  output logic                         irq,
  output logic                         sclk,
  output logic                         mosi,
  input  logic                         miso,
  output logic [NUM_CS-1:0]            cs_n
);
  localparam int AW  = $clog2(BUF_BYTES);
  localparam int CSW = $clog2(NUM_CS);
  localparam int PW  = $clog2(NUM_PROF);
  localparam int CW  = AW + 2;
  localparam logic [12:0] MAXLEN = 13'(BUF_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_LOAD, S_SHIFT, S_STORE, S_DONE} state_t;

  state_t          st;
  logic [7:0]      mem [BUF_BYTES];
  logic [CSW-1:0]  cs_q;
  logic            cpha_q, cpol_l, cpol_q, mask_q, stat_q, cs_on, ph, mosi_q;
  logic [3:0]      pre_q, h;
  logic [1:0]      op_q;
  logic [CW-1:0]   idx, total;
  logic [7:0]      txsh, rxsh;
  logic [NUM_PROF-1:0] prof_cpha;
  logic [3:0]      prof_pre [NUM_PROF];

  wire [15:0]   hdr    = {mem[0], mem[1]};
  wire [2:0]    hop    = hdr[15:13];
  wire [12:0]   hlen   = hdr[12:0];
  wire          hdr_ok = (hop >= 3'd1) && (hop <= 3'd3) && (hlen != 13'd0) && (hlen <= MAXLEN);
  wire          start  = reg_we && (reg_sel == 3'd0) && reg_wdata[15];
  wire [PW-1:0] sprof  = reg_wdata[8 +: PW];
  wire          tx_ph  = (op_q != 2'd3) || (idx < CW'(pre_q));
  wire          rx_keep = (op_q == 2'd1) || ((op_q == 2'd3) && !tx_ph);
  wire [AW-1:0] tx_addr = AW'(idx + CW'(2));
  wire [AW-1:0] rx_addr = (op_q == 2'd3) ? AW'(idx - CW'(pre_q)) : AW'(idx);
  wire [7:0]    tx_byte = tx_ph ? mem[tx_addr] : 8'h00;
  wire          samp    = (h[0] == cpha_q);

  assign busy       = (st != S_IDLE);
  assign sclk       = busy ? (ph ^ cpol_l) : cpol_q;
  assign mosi       = mosi_q;
  assign int_status = stat_q;
  assign irq        = stat_q & mask_q;
  assign buf_rdata  = mem[buf_addr];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_on && (cs_q == CSW'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cs_q <= '0;  cpha_q <= 1'b0;  cpol_l <= 1'b0;  cpol_q <= 1'b0;
      mask_q <= 1'b0; stat_q <= 1'b0; cs_on <= 1'b0; ph <= 1'b0;   mosi_q <= 1'b0;
      pre_q <= '0;   h <= '0;     op_q <= '0;     idx <= '0;      total <= '0;
      txsh <= '0;    rxsh <= '0;  prof_cpha <= '0;
      for (int i = 0; i < NUM_PROF; i++) prof_pre[i] <= '0;
    end else begin
      if (reg_we && reg_sel == 3'd1) cpol_q <= reg_wdata[0];
      if (reg_we && reg_sel == 3'd2) mask_q <= reg_wdata[0];
      if (reg_we && reg_sel == 3'd4) begin
        prof_cpha[sprof] <= reg_wdata[4];
        prof_pre[sprof]  <= reg_wdata[3:0];
      end
      if (reg_we && reg_sel == 3'd3 && (&reg_wdata)) stat_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cs_q   <= reg_wdata[CSW-1:0];
          cpha_q <= prof_cpha[sprof];
          pre_q  <= prof_pre[sprof];
          cpol_l <= cpol_q;
          st     <= S_HDR;
        end
        S_HDR: begin
          op_q  <= hop[1:0];
          idx   <= '0;
          total <= (hop == 3'd3) ? CW'(hlen) + CW'(pre_q) : CW'(hlen);
          if (hdr_ok) begin
            cs_on <= 1'b1;
            st    <= S_LOAD;
          end else st <= S_DONE;
        end
        S_LOAD: begin
          h <= '0;
          if (cpha_q) txsh <= tx_byte;
          else begin
            mosi_q <= tx_byte[7];
            txsh   <= {tx_byte[6:0], 1'b0};
          end
          st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          ph <= ~ph;
          h  <= h + 4'd1;
          if (samp) rxsh <= {rxsh[6:0], miso};
          else begin
            mosi_q <= txsh[7];
            txsh   <= {txsh[6:0], 1'b0};
          end
          if (h == 4'd15) st <= S_STORE;
        end
        S_STORE: begin
          idx <= idx + CW'(1);
          st  <= (idx + CW'(1) == total) ? S_DONE : S_LOAD;
        end
        S_DONE: begin
          cs_on  <= 1'b0;
          stat_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_STORE && rx_keep) mem[rx_addr] <= rxsh;
    else if (buf_we && st == S_IDLE) mem[buf_addr] <= buf_wdata;
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              busy,
  input logic              sclk,
  input logic              int_status,
  input logic              irq,
  input logic [NUM_CS-1:0] cs_n
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1); // R6
  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (&cs_n)); // R6
  AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> int_status); // R9
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) irq |-> int_status); // R9
  AST_SCLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (busy && !tick) |=> (!busy || $stable(sclk))); // R7
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .sclk(sclk),
  .int_status(int_status), .irq(irq), .cs_n(cs_n)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        buf_we = 1'b0, reg_we = 1'b0, miso = 1'b0;
  logic [8:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0, buf_rdata;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        busy, int_status, irq, sclk, mosi;
  logic [7:0]  cs_n;

  spi_cmd_engine i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .int_status(int_status), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #10 clk = ~clk;
  always @(negedge clk) tick <= !tick;

  int n_tests = 0, n_fail = 0;
  logic [7:0] shadow [512];
  logic [7:0] srx [64];
  logic [7:0] cap [64];
  int nb = 0, edges = 0;
  logic [7:0] cs_seen = '0;
  bit cfg_cpol = 0, cfg_cpha = 0;
  logic act_p = 1'b0, sclk_p = 1'b0;

  function automatic logic sbit(input int n);
    if (n / 8 < 64) return srx[n/8][7 - (n % 8)];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    logic act, lead, smp;
    act = ~&cs_n;
    cs_seen = cs_seen | ~cs_n;
    if (sclk !== sclk_p) edges++;
    if (act && !act_p && !cfg_cpha) miso = sbit(0);
    if (act && sclk !== sclk_p) begin
      lead = (sclk != cfg_cpol);
      smp  = cfg_cpha ? !lead : lead;
      if (smp) begin
        if (nb / 8 < 64) cap[nb/8][7 - (nb % 8)] = mosi;
        nb++;
      end else miso = sbit(nb);
    end
    act_p = act;
    sclk_p = sclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr_buf_raw(input int a, input logic [7:0] d);
    @(negedge clk); buf_addr = 9'(a); buf_wdata = d; buf_we = 1'b1;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wr_buf(input int a, input logic [7:0] d);
    wr_buf_raw(a, d);
    shadow[a] = d;
  endtask

  task automatic rd_buf(input int a, output logic [7:0] d);
    buf_addr = 9'(a); #1; d = buf_rdata;
  endtask

  task automatic prep(input logic [2:0] op, input int len, input int pre,
                      input bit cpha, input bit cpol, input int prof);
    logic [15:0] hdr;
    int top;
    wr_reg(3'd3, 16'hFFFF);
    cfg_cpha = cpha; cfg_cpol = cpol;
    wr_reg(3'd4, 16'((prof << 8) | (int'(cpha) << 4) | pre));
    wr_reg(3'd1, 16'(cpol));
    hdr = {op, 13'(len)};
    wr_buf(0, hdr[15:8]);
    wr_buf(1, hdr[7:0]);
    top = pre + len + 4;
    if (top > 60) top = 60;
    for (int k = 2; k < top; k++) wr_buf(k, 8'($urandom));
    for (int k = 0; k < 64; k++) begin srx[k] = 8'($urandom); cap[k] = 8'h00; end
    @(negedge clk);
    nb = 0; edges = 0; cs_seen = '0;
  endtask

  task automatic go(input int cs, input int prof);
    wr_reg(3'd0, 16'(16'h8000 | (prof << 8) | cs));
  endtask

  task automatic fin(input logic [2:0] op, input int len, input int pre, input int cs);
    int g, nwire, top;
    string rq;
    logic [7:0] d, e;
    g = 0;
    while (busy && g < 50000) begin @(negedge clk); g++; end
    nwire = (op >= 3'd1 && op <= 3'd3 && len >= 1 && len <= 512) ? ((op == 3'd3) ? pre + len : len) : 0;
    rq = (nwire == 0) ? "R5" : (op == 3'd2) ? "R2" : (op == 3'd1) ? "R3" : "R4";
    chk(nb == nwire * 8, {"R1 wire bit count ", rq}, nb, nwire * 8);
    chk(edges == nwire * 16, {"R7 sclk edge count ", rq}, edges, nwire * 16);
    chk(cs_seen == ((nwire != 0) ? 8'(1 << cs) : 8'h00), {"R6 chip select used ", rq}, cs_seen, (nwire != 0) ? (1 << cs) : 0);
    for (int k = 0; k < nwire && k < 64; k++) begin
      e = (op == 3'd3 && k >= pre) ? 8'h00 : shadow[2 + k];
      chk(cap[k] == e, {rq, " mosi byte"}, cap[k], e);
    end
    if (nwire != 0 && op == 3'd1) for (int k = 0; k < len; k++) shadow[k] = srx[k];
    if (nwire != 0 && op == 3'd3) for (int j = 0; j < len; j++) shadow[j] = srx[pre + j];
    top = len + 4;
    if (top > 60) top = 60;
    for (int k = 0; k < top; k++) begin
      rd_buf(k, d);
      chk(d == shadow[k], {rq, " buffer byte"}, d, shadow[k]);
    end
    chk(int_status == 1'b1, "R9 status set on completion", int_status, 1);
    chk(&cs_n, "R6 chip selects released", cs_n, 8'hFF);
    chk(sclk == cfg_cpol, "R7 clock back at idle level", sclk, cfg_cpol);
  endtask

  task automatic do_txn(input logic [2:0] op, input int len, input int pre, input bit cpha,
                        input bit cpol, input int cs, input int prof);
    prep(op, len, pre, cpha, cpol, prof);
    go(cs, prof);
    fin(op, len, pre, cs);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] d;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy after reset", busy, 0);
    chk(cs_n == 8'hFF, "R10 cs_n after reset", cs_n, 8'hFF);
    chk(int_status == 1'b0, "R10 status after reset", int_status, 0);
    chk(irq == 1'b0, "R10 irq after reset", irq, 0);
    chk(sclk == 1'b0, "R10 sclk after reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_txn(3'd2, 3, 0, 0, 0, 5, 1);
    do_txn(3'd2, 2, 3, 1, 0, 3, 4);
    do_txn(3'd1, 4, 0, 1, 1, 0, 2);
    do_txn(3'd3, 2, 15, 0, 1, 7, 7);
    do_txn(3'd3, 3, 0, 1, 0, 1, 0);
    do_txn(3'd0, 5, 2, 0, 0, 4, 3);
    do_txn(3'd5, 3, 0, 1, 1, 2, 3);
    do_txn(3'd2, 0, 0, 0, 0, 6, 5);
    do_txn(3'd3, 513, 1, 0, 0, 6, 5);

    wr_reg(3'd2, 16'h0000);
    do_txn(3'd2, 1, 0, 0, 0, 2, 0);
    chk(irq == 1'b0, "R9 irq held low while masked", irq, 0);
    wr_reg(3'd2, 16'h0001);
    chk(irq == 1'b1, "R9 irq rises when unmasked", irq, 1);
    wr_reg(3'd3, 16'h00FF);
    chk(int_status == 1'b1, "R9 partial clear value ignored", int_status, 1);
    wr_reg(3'd3, 16'hFFFF);
    chk(int_status == 1'b0, "R9 status cleared by all ones", int_status, 0);
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);

    wr_buf(40, 8'h3C);
    prep(3'd2, 6, 0, 0, 0, 1);
    go(2, 1);
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    wr_reg(3'd0, 16'h8006);
    wr_buf_raw(40, 8'hA5);
    fin(3'd2, 6, 0, 2);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R8 start during busy not queued", busy, 0);
    chk(cs_seen == 8'h04, "R8 start during busy ignored", cs_seen, 8'h04);
    rd_buf(40, d);
    chk(d == 8'h3C, "R8 buffer write during busy ignored", d, 8'h3C);

    wr_reg(3'd1, 16'h0001);
    chk(sclk == 1'b1, "R7 idle level high", sclk, 1);
    wr_reg(3'd1, 16'h0000);
    chk(sclk == 1'b0, "R7 idle level low", sclk, 0);

    for (int t = 0; t < 30; t++) begin
      do_txn(3'(1 + ($urandom % 3)), 1 + int'($urandom % 16), int'($urandom % 16),
             1'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 8));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule